// File: doc/BRIEF.md
# Auto-Modifying Address Register Unit

This block keeps a bank of eight 32-bit pointer registers and turns an operand request into a memory address under one of three indirect modes. In plain indirect mode, the selected register is the address and the register does not change. In post-increment mode, the register value is issued as the address, and the register then advances by the operand size. In pre-decrement mode, the register first steps back by the operand size, and the lowered value is issued as the address.

The step is 1, 2 or 4 bytes for byte, word or long operands. Register 7 acts as the stack pointer. A byte access through register 7 in either auto-modifying mode steps by 2, so that register 7 stays on a word boundary.

A separate write port loads a register with a starting pointer. If that write lands on the same cycle as a request to the same register, the write wins. Results are registered and appear one clock after the request. The register update is committed on that same edge.

Top module: `addr_reg_unit`

## Requirements
- R1: After the asynchronous active-low reset, `valid_o` is 0, and a plain access to any register returns address 0.
- R2: A direct write (`wr_en_i`=1) stores `wr_data_i` into register `wr_idx_i` on the clock edge. A later plain access to that register returns the written value.
- R3: Plain mode (`mode_i`=2'b00) returns the register value on `ea_o` and on `upd_data_o`, and leaves the register unchanged.
- R4: Post-increment mode (`mode_i`=2'b01) returns the old register value on `ea_o`. The register becomes the old value plus the step, and this new value is shown on `upd_data_o`.
- R5: Pre-decrement mode (`mode_i`=2'b10) lowers the register by the step. The lowered value is returned on both `ea_o` and `upd_data_o`.
- R6: The step is set by `size_i`: 2'b00 byte gives 1, 2'b01 word gives 2, 2'b10 long gives 4, and 2'b11 is treated as long (4).
- R7: A byte access through register 7 in post-increment or pre-decrement mode uses a step of 2. A byte access through any other register uses 1.
- R8: All pointer updates wrap modulo 2^32.
- R9: `ea_o`, `upd_data_o` and `valid_o` update on the clock edge that samples `req_i`. `valid_o` is 1 for each cycle in which a request was sampled and 0 otherwise.
- R10: A direct write to the register selected by a request on the same cycle takes priority. The register and `upd_data_o` take `wr_data_i`, while `ea_o` is still formed from the pre-write contents.
- R11: The reserved mode 2'b11 behaves as plain indirect: there is no register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operand access request |
| reg_idx_i | input | 3 | Register selected by the request |
| mode_i | input | 2 | 00 plain, 01 post-increment, 10 pre-decrement, 11 reserved (plain) |
| size_i | input | 2 | 00 byte, 01 word, 10 long, 11 long |
| wr_en_i | input | 1 | Direct register write enable |
| wr_idx_i | input | 3 | Register index for the direct write |
| wr_data_i | input | 32 | Value for the direct write |
| ea_o | output | 32 | Effective address of the last request |
| valid_o | output | 1 | A request was sampled on the last edge |
| upd_data_o | output | 32 | Register contents after the last request |

## Verification
Each access result (`ea_o`, `upd_data_o`, `valid_o`) is due one edge after `req_i` is sampled. A direct write becomes visible through a plain access issued on a following cycle. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the capturing edge. Expected addresses come from a shadow copy of the register bank kept in the bench, which applies the step rules itself. After every auto-modifying case, a follow-up plain access confirms what the register really holds.

// File: rtl/aru_pkg.sv
package aru_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_POST  = 2'b01,
    MODE_PRE   = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;
endpackage

// File: rtl/aru_step.sv
module aru_step #(
  parameter int AW     = 32,
  parameter int IW     = 3,
  parameter int SP_IDX = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    size_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] step_o
);
  import aru_pkg::*;
  localparam logic [IW-1:0] SpIdx = IW'(SP_IDX);

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: step_o = (idx_i == SpIdx) ? AW'(2) : AW'(1);
      SZ_WORD: step_o = AW'(2);
      default: step_o = AW'(4);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      AST_STEP_POW2: assert ($countones(step_o) == 1 && step_o <= AW'(4)); // R6
    end
  end
endmodule

// File: rtl/aru_regfile.sv
module aru_regfile #(
  parameter int AW       = 32,
  parameter int NUM_REGS = 8,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [IW-1:0] upd_idx_i,
  input  logic [AW-1:0] upd_data_i
);
  logic [NUM_REGS-1:0][AW-1:0] regs;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [AW-1:0] q;
    // direct write outranks the auto-modify path
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))      q <= wr_data_i;
      else if (upd_en_i && upd_idx_i == IW'(g))    q <= upd_data_i;
    end
    assign regs[g] = q;
  end

  assign rd_data_o = regs[rd_idx_i];

  AST_WR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs[$past(wr_idx_i)] == $past(wr_data_i)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !upd_en_i) |=> $stable(regs)); // R3
endmodule

// File: rtl/addr_reg_unit.sv
module addr_reg_unit #(
  parameter int AW       = 32,
  parameter int NUM_REGS = 8,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [IW-1:0] reg_idx_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  output logic [AW-1:0] ea_o,
  output logic          valid_o,
  output logic [AW-1:0] upd_data_o
);
  import aru_pkg::*;

  logic [AW-1:0] cur, step, nxt, ea_d, upd_d;
  logic          upd_en, hit;
  mode_e         mode;

  assign mode = mode_e'(mode_i);

  aru_step #(.AW(AW), .IW(IW), .SP_IDX(NUM_REGS-1)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .size_i (size_i),
    .idx_i  (reg_idx_i),
    .step_o (step)
  );

  aru_regfile #(.AW(AW), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (reg_idx_i),
    .rd_data_o  (cur),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .upd_en_i   (upd_en),
    .upd_idx_i  (reg_idx_i),
    .upd_data_i (nxt)
  );

  always_comb begin
    nxt    = cur;
    ea_d   = cur;
    upd_en = 1'b0;
    unique case (mode)
      MODE_POST: begin nxt = cur + step; upd_en = req_i; end
      MODE_PRE:  begin nxt = cur - step; ea_d = nxt; upd_en = req_i; end
      default:   ;
    endcase
  end

  assign hit   = wr_en_i && (wr_idx_i == reg_idx_i);
  assign upd_d = hit ? wr_data_i : nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      ea_o       <= '0;
      upd_data_o <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        ea_o       <= ea_d;
        upd_data_o <= upd_d;
      end
    end
  end

  AST_VALID_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R9
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R9
  AST_POST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b01 && !hit) |=> upd_data_o == ea_o + $past(step)); // R4
  AST_PRE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b10 && !hit) |=> upd_data_o == ea_o); // R5
  AST_PLAIN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i[1] == mode_i[0] && !hit) |=> upd_data_o == ea_o); // R11
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit) |=> upd_data_o == $past(wr_data_i)); // R10
endmodule

// File: tb/addr_reg_unit_test.sv
module addr_reg_unit_test;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, wr_en = 0;
  logic [2:0]  idx = 0, widx = 0;
  logic [1:0]  mode = 0, size = 0;
  logic [31:0] wdata = 0;
  logic [31:0] ea, upd;
  logic        valid;
  int checks = 0, fails = 0;
  logic [31:0] model [8];

  always #5 clk = ~clk;

  addr_reg_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .reg_idx_i(idx), .mode_i(mode),
    .size_i(size), .wr_en_i(wr_en), .wr_idx_i(widx), .wr_data_i(wdata),
    .ea_o(ea), .valid_o(valid), .upd_data_o(upd)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] step_of(logic [2:0] i, logic [1:0] s);
    if (s == 2'b00) return (i == 3'd7) ? 32'd2 : 32'd1;
    if (s == 2'b01) return 32'd2;
    return 32'd4;
  endfunction

  task automatic write_reg(logic [2:0] i, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; widx = i; wdata = d;
    @(negedge clk);
    wr_en = 0;
    model[i] = d;
  endtask

  // one access, expectations from the shadow bank
  task automatic access(string tag, logic [2:0] i, logic [1:0] m, logic [1:0] s);
    logic [31:0] e_ea, e_up;
    e_ea = model[i]; e_up = model[i];
    if (m == 2'b01) e_up = model[i] + step_of(i, s);
    if (m == 2'b10) begin e_up = model[i] - step_of(i, s); e_ea = e_up; end
    @(negedge clk);
    req = 1; idx = i; mode = m; size = s;
    @(negedge clk);
    req = 0;
    check({tag, " valid"}, {31'd0, valid}, 32'd1);
    check({tag, " ea"}, ea, e_ea);
    check({tag, " upd"}, upd, e_up);
    model[i] = e_up;
  endtask

  task automatic t_reset;
    check("R1 valid after reset", {31'd0, valid}, 32'd0);
    access("R1 reg3 zero", 3'd3, 2'b00, 2'b10);
    access("R1 reg7 zero", 3'd7, 2'b00, 2'b00);
  endtask

  task automatic t_write_plain;
    write_reg(3'd0, 32'h1001);
    access("R2 load reg0", 3'd0, 2'b00, 2'b00);
    access("R3 plain unchanged", 3'd0, 2'b00, 2'b10);
  endtask

  task automatic t_post;
    access("R4 byte post 1001", 3'd0, 2'b01, 2'b00);
    check("R4 ea is 1001", ea, 32'h1001);
    check("R4 reg is 1002", upd, 32'h1002);
    access("R4 follow plain", 3'd0, 2'b00, 2'b00);
    write_reg(3'd1, 32'h100);
    access("R6 word post", 3'd1, 2'b01, 2'b01);
    access("R6 long post", 3'd1, 2'b01, 2'b10);
    access("R6 size11 post", 3'd1, 2'b01, 2'b11);
    check("R6 reg1 value", upd, 32'h10a);
  endtask

  task automatic t_pre;
    write_reg(3'd2, 32'h200);
    access("R5 long pre", 3'd2, 2'b10, 2'b10);
    access("R5 word pre", 3'd2, 2'b10, 2'b01);
    access("R5 byte pre", 3'd2, 2'b10, 2'b00);
    check("R5 final ea", ea, 32'h1f9);
    access("R5 follow plain", 3'd2, 2'b00, 2'b00);
  endtask

  task automatic t_sp;
    write_reg(3'd7, 32'h1000);
    access("R7 sp byte post", 3'd7, 2'b01, 2'b00);
    check("R7 sp stepped 2", upd, 32'h1002);
    access("R7 sp byte pre", 3'd7, 2'b10, 2'b00);
    check("R7 sp back", ea, 32'h1000);
    access("R7 sp word post", 3'd7, 2'b01, 2'b01);
    write_reg(3'd6, 32'h1000);
    access("R7 reg6 byte post", 3'd6, 2'b01, 2'b00);
    check("R7 reg6 stepped 1", upd, 32'h1001);
  endtask

  task automatic t_wrap;
    write_reg(3'd3, 32'hffff_fffe);
    access("R8 long post wrap", 3'd3, 2'b01, 2'b10);
    check("R8 wrapped to 2", upd, 32'h2);
    write_reg(3'd4, 32'h0);
    access("R8 byte pre wrap", 3'd4, 2'b10, 2'b00);
    check("R8 wrapped to ffffffff", ea, 32'hffff_ffff);
  endtask

  task automatic t_timing;
    write_reg(3'd5, 32'h40);
    @(negedge clk);
    req = 1; idx = 3'd5; mode = 2'b01; size = 2'b10;
    check("R9 not before edge", {31'd0, valid}, 32'd0);
    @(negedge clk);
    req = 0;
    check("R9 valid after edge", {31'd0, valid}, 32'd1);
    check("R9 ea after edge", ea, 32'h40);
    @(negedge clk);
    check("R9 valid drops", {31'd0, valid}, 32'd0);
    model[5] = 32'h44;
    access("R9 follow plain", 3'd5, 2'b00, 2'b00);
  endtask

  task automatic t_conflict;
    @(negedge clk);
    req = 1; idx = 3'd5; mode = 2'b01; size = 2'b10;
    wr_en = 1; widx = 3'd5; wdata = 32'h77;
    @(negedge clk);
    req = 0; wr_en = 0;
    check("R10 ea old value", ea, 32'h44);
    check("R10 upd write wins", upd, 32'h77);
    model[5] = 32'h77;
    access("R10 reg holds write", 3'd5, 2'b00, 2'b00);
    @(negedge clk);
    req = 1; idx = 3'd5; mode = 2'b10; size = 2'b01;
    wr_en = 1; widx = 3'd1; wdata = 32'h99;
    @(negedge clk);
    req = 0; wr_en = 0;
    check("R10 other reg pre ea", ea, 32'h75);
    model[5] = 32'h75; model[1] = 32'h99;
    access("R10 other reg written", 3'd1, 2'b00, 2'b00);
  endtask

  task automatic t_rsvd;
    access("R11 rsvd mode", 3'd0, 2'b11, 2'b10);
    access("R11 follow plain", 3'd0, 2'b00, 2'b00);
    check("R11 reg0 kept", ea, 32'h1002);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_plain();
    t_post();
    t_pre();
    t_sp();
    t_wrap();
    t_timing();
    t_conflict();
    t_rsvd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule